// File: doc/BRIEF.md
# Stochastic-Rounding Int8 Requantizer

This block takes a stream of signed fixed-point words, typically an accumulator value already multiplied by a quantization factor, and reduces each one to an 8-bit integer. The input carries `FRAC_W` fraction bits. The block drops them by rounding, then optionally adds a zero point, then clips the result to the range of the selected output mode. Each accepted word produces one result on the following clock edge. A flag marks every result that clipping changed.

Three output modes are available:
- A symmetric signed range for weights.
- An asymmetric signed range with a signed zero point for general activations.
- An unsigned range for nonnegative ReLU outputs.

Rounding is selected per word. It is either round-to-nearest or stochastic. In stochastic mode the word rounds up with a probability equal to its discarded fraction. The random threshold comes from an internal 16-bit linear-feedback shift register, which software can reseed for reproducible runs.

Top module: `stoch_quant`

## Requirements
- R1: A word presented with `valid_i` high is accepted on that rising edge, and its result appears on `data_o`/`sat_o` with `valid_o` high exactly one cycle later. `valid_o` is low in every cycle after a cycle without `valid_i`.
- R2: `mode_i` = 2'b00 (symmetric) clips the rounded integer to [-127, 127]. A result of -128 never appears in this mode. `mode_i` = 2'b11 behaves the same as 2'b00.
- R3: `mode_i` = 2'b01 (asymmetric) adds the signed 8-bit `zero_pt_i` to the rounded integer and clips the sum to [-128, 127].
- R4: `mode_i` = 2'b10 (unsigned) clips the rounded integer to [0, 255]. `data_o` is then read as unsigned. Any input below -1.0 gives 0 with the saturation flag set.
- R5: With `round_sel_i` = 0 (nearest), the result is the closest integer, and exact halves round away from zero (2.5 gives 3, -2.5 gives -3).
- R6: With `round_sel_i` = 1 (stochastic), the result is floor(value), taken toward negative infinity, plus one exactly when the fraction bits, left-aligned to 16 bits and read as unsigned, are strictly greater than the current LFSR state.
- R7: The LFSR resets to 16'hACE1 and never holds zero. On each accepted word it steps as next = {s[14:0], s[15]^s[13]^s[12]^s[10]}. It holds when no word is accepted.
- R8: `seed_load_i` loads `seed_i` into the LFSR, replacing a zero seed with 16'h0001. A load wins over a step. A word accepted in the same cycle as a load uses the state from before the load.
- R9: `sat_o` is 1 exactly when clipping changed the value. `data_o` and `sat_o` hold their last values while no word is accepted, and reset to 0.
- R10: Over 1024 consecutive stochastic roundings of the same value with fraction 0.25, the count of rounded-up results lies within 256 ± 64.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word valid |
| data_i | input | IN_W | Signed fixed-point input with FRAC_W fraction bits |
| mode_i | input | 2 | Output range: 00 symmetric, 01 asymmetric, 10 unsigned, 11 symmetric |
| round_sel_i | input | 1 | 0 nearest, 1 stochastic |
| zero_pt_i | input | 8 | Signed zero point added in asymmetric mode |
| seed_load_i | input | 1 | Load LFSR seed |
| seed_i | input | 16 | LFSR seed value |
| valid_o | output | 1 | Result valid |
| data_o | output | 8 | Quantized result |
| sat_o | output | 1 | Result was clipped |

## Verification
A wrong LFSR state shows up in the first stochastic result whose fraction falls between the true and the wrong threshold. The bench models the register sequence word by word, so a single missed or extra step breaks agreement within a few accepted words. Errors in the floor, half-rounding or clip bounds appear on the very word that hits them, one cycle after acceptance. For that reason every fraction and every integer in a small configuration is swept in each mode.

// File: rtl/sq_pkg.sv
package sq_pkg;
  localparam int LFSR_W = 16;

  typedef enum logic [1:0] {
    QM_SYM  = 2'b00,
    QM_ASYM = 2'b01,
    QM_UNS  = 2'b10,
    QM_SYMX = 2'b11
  } qmode_e;
endpackage

// File: rtl/sq_lfsr.sv
module sq_lfsr
  import sq_pkg::*;
#(
  parameter logic [LFSR_W-1:0] RST_VAL = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic [LFSR_W-1:0] state_o
);
  logic [LFSR_W-1:0] s_q;
  logic              fb;

  // x^16 + x^14 + x^13 + x^11 + 1, maximal length
  assign fb = s_q[15] ^ s_q[13] ^ s_q[12] ^ s_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      s_q <= RST_VAL;
    else if (load_i)  s_q <= (seed_i == '0) ? LFSR_W'(1) : seed_i;
    else if (step_i)  s_q <= {s_q[LFSR_W-2:0], fb};
  end

  assign state_o = s_q;
endmodule

// File: rtl/sq_round.sv
module sq_round
  import sq_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 8
) (
  input  logic [IN_W-1:0]             data_i,
  input  logic                        stoch_i,
  input  logic [LFSR_W-1:0]           thr_i,
  output logic signed [IN_W-FRAC_W:0] int_o
);
  localparam int IW = IN_W - FRAC_W;
  localparam int OW = IW + 1;
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  logic signed [IW-1:0] flr;
  logic [FRAC_W-1:0]    frac;
  logic [LFSR_W-1:0]    frac_al;
  logic                 neg, inc;

  assign flr     = data_i[IN_W-1:FRAC_W];   // arithmetic floor
  assign frac    = data_i[FRAC_W-1:0];
  assign frac_al = LFSR_W'(frac) << (LFSR_W - FRAC_W);
  assign neg     = data_i[IN_W-1];

  always_comb begin
    if (stoch_i) inc = frac_al > thr_i;
    else if (neg) inc = frac > HALF;         // half goes toward -inf on the floor: away from zero
    else          inc = frac >= HALF;
  end

  assign int_o = OW'(flr) + OW'(inc);
endmodule

// File: rtl/sq_clip.sv
module sq_clip
  import sq_pkg::*;
#(
  parameter int VAL_W = 17
) (
  input  logic signed [VAL_W-1:0] val_i,
  input  qmode_e                  mode_i,
  input  logic signed [7:0]       zp_i,
  output logic [7:0]              q_o,
  output logic                    sat_o
);
  localparam int SW = VAL_W + 1;

  logic signed [SW-1:0] sum, lo, hi;

  always_comb begin
    sum = (mode_i == QM_ASYM) ? SW'(val_i) + SW'(zp_i) : SW'(val_i);
    unique case (mode_i)
      QM_ASYM: begin lo = SW'(-128); hi = SW'(127); end
      QM_UNS:  begin lo = SW'(0);    hi = SW'(255); end
      default: begin lo = SW'(-127); hi = SW'(127); end
    endcase
    if (sum < lo) begin
      q_o = lo[7:0]; sat_o = 1'b1;
    end else if (sum > hi) begin
      q_o = hi[7:0]; sat_o = 1'b1;
    end else begin
      q_o = sum[7:0]; sat_o = 1'b0;
    end
  end
endmodule

// File: rtl/stoch_quant.sv
module stoch_quant
  import sq_pkg::*;
#(
  parameter int                IN_W     = 24,
  parameter int                FRAC_W   = 8,
  parameter logic [LFSR_W-1:0] LFSR_RST = 16'hACE1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [IN_W-1:0]   data_i,
  input  logic [1:0]        mode_i,
  input  logic              round_sel_i,
  input  logic [7:0]        zero_pt_i,
  input  logic              seed_load_i,
  input  logic [LFSR_W-1:0] seed_i,
  output logic              valid_o,
  output logic [7:0]        data_o,
  output logic              sat_o
);
  localparam int INT_W = IN_W - FRAC_W + 1;

  logic [LFSR_W-1:0]       lfsr_q;
  logic signed [INT_W-1:0] rnd;
  logic [7:0]              q;
  logic                    sat;

  sq_lfsr #(.RST_VAL(LFSR_RST)) i_lfsr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (valid_i),
    .load_i  (seed_load_i),
    .seed_i  (seed_i),
    .state_o (lfsr_q)
  );

  sq_round #(.IN_W(IN_W), .FRAC_W(FRAC_W)) i_round (
    .data_i  (data_i),
    .stoch_i (round_sel_i),
    .thr_i   (lfsr_q),
    .int_o   (rnd)
  );

  sq_clip #(.VAL_W(INT_W)) i_clip (
    .val_i  (rnd),
    .mode_i (qmode_e'(mode_i)),
    .zp_i   (zero_pt_i),
    .q_o    (q),
    .sat_o  (sat)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      data_o  <= '0;
      sat_o   <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        data_o <= q;
        sat_o  <= sat;
      end
    end
  end
endmodule

// File: rtl/sq_quant_chk.sv
module sq_quant_chk
  import sq_pkg::*;
#(
  parameter int IN_W   = 24,
  parameter int FRAC_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [IN_W-1:0]   data_i,
  input logic [1:0]        mode_i,
  input logic              seed_load_i,
  input logic              valid_o,
  input logic [7:0]        data_o,
  input logic              sat_o,
  input logic [LFSR_W-1:0] lfsr_q
);
  // R1
  valid_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R1
  idle_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);
  // R2
  sym_no_min_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mode_i == QM_SYM) |=> data_o != 8'h80);
  // R4
  uns_neg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && (mode_i == QM_UNS) && ($signed(data_i) < -(2 ** FRAC_W))
    |=> sat_o && (data_o == 8'h00));
  // R7
  lfsr_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lfsr_q != '0);
  // R7
  lfsr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i && !seed_load_i |=> $stable(lfsr_q));
  // R9
  out_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(data_o) && $stable(sat_o));
endmodule

bind stoch_quant sq_quant_chk #(.IN_W(IN_W), .FRAC_W(FRAC_W)) i_chk (.*);

// File: tb/test_stoch_quant.sv
module test_stoch_quant;
  localparam int IN_W = 14;
  localparam int F    = 4;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            valid_i = 1'b0;
  logic [IN_W-1:0] data_i = '0;
  logic [1:0]      mode_i = 2'b00;
  logic            round_sel_i = 1'b0;
  logic [7:0]      zero_pt_i = '0;
  logic            seed_load_i = 1'b0;
  logic [15:0]     seed_i = '0;
  logic            valid_o;
  logic [7:0]      data_o;
  logic            sat_o;

  int errors = 0;
  int checks = 0;
  logic [15:0] m_lfsr = 16'hACE1;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  stoch_quant #(.IN_W(IN_W), .FRAC_W(F)) i_stoch_quant (.*);

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] lfsr_next(logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  // returns {sat, q}
  function automatic logic [8:0] model(int x, int mode, bit rs, int zp, logic [15:0] l);
    int fl, fr, r, lo, hi;
    bit inc, sat;
    fl = x >>> F;
    fr = x - fl * (2 ** F);
    if (rs) inc = (fr * (2 ** (16 - F))) > int'(l);
    else if (x < 0) inc = 2 * fr > 2 ** F;
    else inc = 2 * fr >= 2 ** F;
    r = fl + int'(inc);
    if (mode == 1) r = r + zp;
    case (mode)
      1: begin lo = -128; hi = 127; end
      2: begin lo = 0;    hi = 255; end
      default: begin lo = -127; hi = 127; end
    endcase
    sat = 0;
    if (r < lo) begin r = lo; sat = 1; end
    else if (r > hi) begin r = hi; sat = 1; end
    return {sat, 8'(r)};
  endfunction

  // Drive at a falling edge, check one cycle later (R1)
  task automatic run(int x, int mode, bit rs, int zp, bit ld, logic [15:0] sd, string req);
    logic [8:0] e;
    e = model(x, mode, rs, zp, m_lfsr);
    data_i = IN_W'(x); mode_i = 2'(mode); round_sel_i = rs;
    zero_pt_i = 8'(zp); seed_load_i = ld; seed_i = sd; valid_i = 1'b1;
    if (ld) m_lfsr = (sd == 16'h0) ? 16'h0001 : sd;
    else m_lfsr = lfsr_next(m_lfsr);
    @(negedge clk_i);
    valid_i = 1'b0; seed_load_i = 1'b0;
    checks++;
    if (valid_o !== 1'b1 || data_o !== e[7:0] || sat_o !== e[8]) begin
      errors++;
      $display("FAIL %s: x=%0d mode=%0d rs=%0d act=%0d/%0d/%0d exp=1/%0d/%0d",
               req, x, mode, rs, valid_o, data_o, sat_o, e[7:0], e[8]);
    end
  endtask

  initial begin
    int ups;
    logic [7:0] held_q;
    logic held_s;
    repeat (3) @(negedge clk_i);
    // R9 reset state
    chk(valid_o == 0 && data_o == 0 && sat_o == 0, "R9 reset", {valid_o, data_o, sat_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R2 R3 R4 R5: nearest, every input
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) run(x, 0, 0, 0, 0, 0, "R2_R5");
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) run(x, 2, 0, 0, 0, 0, "R4_R5");
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) run(x, 1, 0, 90, 0, 0, "R3_R5");
    // R5 explicit halves
    run(40, 0, 0, 0, 0, 0, "R5 +2.5");
    chk(data_o == 8'd3, "R5 2.5->3", data_o, 3);
    run(-40, 0, 0, 0, 0, 0, "R5 -2.5");
    chk(data_o == 8'hFD, "R5 -2.5->-3", data_o, 253);

    // R6 R7: stochastic, every input, LFSR stepping per word
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) run(x, 0, 1, 0, 0, 0, "R6_R7 sym");
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) run(x, 2, 1, 0, 0, 0, "R6 uns");
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x++) run(x, 1, 1, -100, 0, 0, "R3_R6");
    // R2 mode 11 acts as symmetric
    for (int x = -(2 ** (IN_W - 1)); x < 2 ** (IN_W - 1); x += 7) run(x, 3, 0, 0, 0, 0, "R2 mode3");
    run(-8000, 3, 0, 0, 0, 0, "R2 mode3 min");
    chk(data_o == 8'h81 && sat_o, "R2 clip -127", data_o, 129);

    // R7 hold on idle cycles, R9 outputs held
    held_q = data_o; held_s = sat_o;
    repeat (5) @(negedge clk_i);
    chk(valid_o == 0 && data_o == held_q && sat_o == held_s, "R9 hold", data_o, held_q);
    run(7, 0, 1, 0, 0, 0, "R7 after idle");

    // R8: zero seed replaced by 1, load without a word
    seed_load_i = 1'b1; seed_i = 16'h0000;
    @(negedge clk_i);
    seed_load_i = 1'b0; m_lfsr = 16'h0001;
    for (int x = 0; x < 64; x++) run(x * 3 + 1, 0, 1, 0, 0, 0, "R8 zero seed");
    // R8: load in same cycle as a word, word uses old state
    run(9, 0, 1, 0, 1, 16'h8000, "R8 load+word");
    for (int x = 0; x < 64; x++) run(x + 1, 1, 1, 5, 0, 0, "R8 after load");

    // R10: rounding-up rate for 1.25
    ups = 0;
    for (int i = 0; i < 1024; i++) begin
      run(20, 0, 1, 0, 0, 0, "R10 sample");
      if (data_o == 8'd2) ups++;
    end
    chk(ups >= 192 && ups <= 320, "R10 rate", ups, 256);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: act=timeout exp=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule